// File: doc/BRIEF.md
# Erasable Memory Device Model

This block is a synthesizable cycle model of a word-wide, electrically programmed and UV-erasable (or one-time-programmable) memory. On every clock it samples the device-level control pins: an active-low chip select, an active-low output gate, an active-low program strobe, a flag saying the programming supply is raised and a flag saying a high voltage sits on the ninth address line. From these it works out the operating mode. The modes are read, output off, standby, program, verify, program lock-out and identifier readout. It then produces a registered data word and a drive-enable flag for an external tri-state bus.

The array is organised as words of DATA_W bits with 2^ADDR_W locations. The full-size part uses ADDR_W = 16 (65,536 words). The default is kept small so that the model elaborates quickly. Programming follows floating-gate rules: a write can only turn ones into zeros, and one is applied on each rising edge of the program strobe. Erased cells read as ones. An abstract synchronous erase input stands in for ultraviolet exposure. Identifier readout returns a manufacturer byte or a device byte, selected by address bit 0, with the upper byte cleared.

Top module: `eprom_model`

## Requirements
- R1: With chip select low, output gate low, strobe high, supply flag low and high-voltage flag low, the clock edge that samples these pins sets dout to the word at addr and sets dout_en to 1.
- R2: With chip select low and output gate high, the next edge clears dout_en and sets dout to zero. Whenever dout_en is 0, dout is zero.
- R3: With chip select high, the next edge clears dout_en, whatever the output gate does.
- R4: A rising edge of the strobe, seen as strobe low at one clock and high at the next, with chip select low and the supply flag set at that second clock, stores old_word AND din at addr. The din and addr used are the values sampled at that second clock, not those seen while the strobe was low.
- R5: A program operation never sets a bit. Writing all ones leaves a word unchanged, and writing a mask clears only the mask's zero bits.
- R6: With chip select low, output gate low, strobe high and the supply flag set, the next edge drives the stored word on dout with dout_en 1.
- R7: With chip select high and the supply flag set, a strobe pulse leaves the array unchanged and dout_en stays 0.
- R8: A strobe pulse with the supply flag low leaves the array unchanged.
- R9: With the read conditions of R1 but the high-voltage flag set, the next edge drives 16'h0020 when addr[0] is 0 and 16'h008C when addr[0] is 1. The other address bits are ignored and bits 15 to 8 are zero.
- R10: After reset, and on the clock after erase is high for one cycle, every word reads all ones. Erase takes priority over a program operation in the same cycle.
- R11: While reset is held low, dout is zero and dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; fills the array with ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line 9 (identifier readout) |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data presented for programming |
| erase | input | 1 | Synchronous erase: all words to ones |
| dout | output | DATA_W | Registered output word (zero when not driving) |
| dout_en | output | 1 | Drive enable for the external tri-state data bus |

## Verification
The bench uses the default parameters: ADDR_W = 10, DATA_W = 16 and the identifier bytes 8'h20 and 8'h8C. With only 1,024 words, the lowest and the top address can both be reached directly, and the erase and reset fills cover the whole array at little cost. The 16-bit width lets the bit-clearing masks and the zero upper byte of the identifier readout be checked exactly. With identifier codes whose values are known, the bench can compare the readout to constants. An address with high bits set shows that only bit 0 picks the identifier byte.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY   = 3'd0,
        MODE_LOCKOUT   = 3'd1,
        MODE_OFF       = 3'd2,
        MODE_READ      = 3'd3,
        MODE_PROGRAM   = 3'd4,
        MODE_VERIFY    = 3'd5,
        MODE_IDENT     = 3'd6
    } mode_t;

    function automatic logic mode_drives(mode_t m);
        return (m == MODE_READ) || (m == MODE_VERIFY) || (m == MODE_IDENT);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    output mode_t mode
);

    always_comb begin
        mode = MODE_OFF;
        if (ce_n) begin
            // deselected: supply level only decides whether a pulse is locked out
            mode = vpp_hi ? MODE_LOCKOUT : MODE_STANDBY;
        end else if (vpp_hi) begin
            if (!pgm_n)
                mode = MODE_PROGRAM;
            else if (!oe_n)
                mode = MODE_VERIFY;
            else
                mode = MODE_OFF;
        end else begin
            if (oe_n || !pgm_n)
                mode = MODE_OFF;
            else if (a9_hv)
                mode = MODE_IDENT;
            else
                mode = MODE_READ;
        end
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    // erased cells are ones; a write can only pull bits to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells_q[i] <= '1;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++)
                cells_q[i] <= '1;
        end else if (wr_en) begin
            cells_q[waddr] <= cells_q[waddr] & wmask;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/eprom_ident.sv
module eprom_ident #(
    parameter int         DATA_W   = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h8C
) (
    input  logic              sel_dev,
    output logic [DATA_W-1:0] code
);

    localparam int PAD_W = DATA_W - 8;

    assign code = {{PAD_W{1'b0}}, (sel_dev ? DEV_CODE : MFR_CODE)};

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic              pgm_q;
        logic              den;
        logic [DATA_W-1:0] word;
    } state_t;

    state_t st_d, st_q;

    mode_t             mode;
    logic [DATA_W-1:0] cell_word;
    logic [DATA_W-1:0] ident_word;
    logic              strobe_rise;
    logic              wr_en;

    eprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    eprom_ident #(
        .DATA_W   (DATA_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_ident (
        .sel_dev (addr[0]),
        .code    (ident_word)
    );

    // one write per strobe pulse, taken at its trailing (rising) edge
    assign strobe_rise = !st_q.pgm_q && pgm_n;
    assign wr_en       = strobe_rise && !ce_n && vpp_hi;

    eprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .wr_en (wr_en),
        .waddr (addr),
        .wmask (din),
        .raddr (addr),
        .rdata (cell_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pgm_q = pgm_n;
        st_d.den   = mode_drives(mode);
        unique case (mode)
            MODE_READ,
            MODE_VERIFY: st_d.word = cell_word;
            MODE_IDENT:  st_d.word = ident_word;
            default:     st_d.word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pgm_q <= 1'b1;
            st_q.den   <= 1'b0;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.word;
    assign dout_en = st_q.den;

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int         ADDR_W   = 10,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h8C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> !dout_en);

    // R2
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && oe_n) |-> !dout_en);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R1
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !oe_n && pgm_n && !vpp_hi && !a9_hv) |-> dout_en);

    // R9
    ident_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv && !addr[0])
        |-> (dout_en && dout == {{(DATA_W-8){1'b0}}, MFR_CODE}));

    // R9
    ident_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv && addr[0])
        |-> (dout_en && dout == {{(DATA_W-8){1'b0}}, DEV_CODE}));

    // R11
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!dout_en && dout == '0);
        end
    end

endmodule

bind eprom_model eprom_model_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/eprom_model_tb.sv
module eprom_model_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic          vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_model dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
        .erase(erase), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic c, logic o, logic p, logic v, logic h,
                         logic [AW-1:0] a, logic [DW-1:0] d);
        ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
        step();
    endtask

    task automatic read_at(logic [AW-1:0] a, string tag, logic [DW-1:0] exp);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, '0);
        step();
        check(tag, dout, exp);
        check(tag, {15'd0, dout_en}, 16'd1);
    endtask

    task automatic pulse(logic c, logic v, logic [AW-1:0] a, logic [DW-1:0] d);
        drive(c, 1'b1, 1'b0, v, 1'b0, a, d);
        step();
        drive(c, 1'b1, 1'b1, v, 1'b0, a, d);
        step();
        idle();
    endtask

    task automatic t_reset();
        check("R11 dout in reset", dout, '0);
        check("R11 dout_en in reset", {15'd0, dout_en}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
    endtask

    task automatic t_blank();
        read_at(10'd0, "R10 blank low word", 16'hFFFF);
        read_at(10'd1023, "R10 blank top word", 16'hFFFF);
        idle();
    endtask

    task automatic t_program();
        pulse(1'b0, 1'b1, 10'd5, 16'h1234);
        read_at(10'd5, "R4 programmed word", 16'h1234);
        read_at(10'd6, "R1 neighbour untouched", 16'hFFFF);
        idle();
    endtask

    task automatic t_clear_only();
        pulse(1'b0, 1'b1, 10'd5, 16'hFFFF);
        read_at(10'd5, "R5 ones do not set", 16'h1234);
        pulse(1'b0, 1'b1, 10'd5, 16'hFF0F);
        read_at(10'd5, "R5 mask clears only zeros", 16'h1204);
        idle();
    endtask

    task automatic t_verify();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, '0);
        step();
        check("R6 verify data", dout, 16'h1204);
        check("R6 verify enable", {15'd0, dout_en}, 16'd1);
        idle();
    endtask

    task automatic t_gate_off();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd5, '0);
        step();
        check("R2 gate off enable", {15'd0, dout_en}, '0);
        check("R2 gate off data", dout, '0);
        idle();
    endtask

    task automatic t_standby();
        drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5, '0);
        step();
        check("R3 standby enable", {15'd0, dout_en}, '0);
        idle();
    endtask

    task automatic t_lockout();
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd5, 16'h0000);
        step();
        check("R7 lockout enable", {15'd0, dout_en}, '0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 16'h0000);
        step();
        idle();
        read_at(10'd5, "R7 lockout no write", 16'h1204);
        idle();
    endtask

    task automatic t_no_supply();
        pulse(1'b0, 1'b0, 10'd5, 16'h0000);
        read_at(10'd5, "R8 no supply no write", 16'h1204);
        idle();
    endtask

    task automatic t_late_data();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd9, 16'h0000);
        for (int i = 0; i < 4; i++) step();
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd9, 16'hA5A5);
        step();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd9, 16'hA5A5);
        step();
        idle();
        read_at(10'd9, "R4 data taken at strobe rise", 16'hA5A5);
        idle();
    endtask

    task automatic t_ident();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd0, '0);
        step();
        check("R9 manufacturer byte", dout, 16'h0020);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'd1, '0);
        step();
        check("R9 device byte", dout, 16'h008C);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h301, '0);
        step();
        check("R9 high address bits ignored", dout, 16'h008C);
        check("R9 ident enable", {15'd0, dout_en}, 16'd1);
        idle();
    endtask

    task automatic t_erase();
        erase = 1'b1;
        step();
        erase = 1'b0;
        read_at(10'd5, "R10 erased word 5", 16'hFFFF);
        read_at(10'd9, "R10 erased word 9", 16'hFFFF);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_blank();
        t_program();
        t_clear_only();
        t_verify();
        t_gate_off();
        t_standby();
        t_lockout();
        t_no_supply();
        t_late_data();
        t_ident();
        t_erase();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule